// File: doc/BRIEF.md
# Bilateral Range-Weight Accumulation Array

This block is the arithmetic core of an edge-preserving bilateral smoother. Each clock it accepts one fully formed 9×9 window of 8-bit pixels together with a valid flag. Every window position has its own processing element. That element takes the absolute intensity difference between its pixel and the window's center pixel. It uses the upper bits of that difference to index a small weight table that belongs to its position alone. It then registers both the weight and the pixel·weight product.

A pipelined adder tree, registered at every level, reduces the 81 products and the 81 weights into two totals. A downstream divider turns the two totals into the smoothed pixel; that divider is not part of this block. The tables are constants fixed at elaboration. Their weights fall off with the spatial distance from the center and with the intensity difference, and the center entry at zero difference is the largest weight. The weight total therefore never reaches zero, so the divide downstream is always defined.

Top module: `bilat_accum_top`

## Requirements
- R1: A window presented with `inValid` high on one rising edge produces `outValid` high with its two totals exactly 8 rising edges later (one element stage plus seven tree levels). A new window may be accepted on every edge.
- R2: The table index of an element is the absolute difference |pixel − center| shifted right by 4 bits, giving 16 entries per position.
- R3: The pixel at row `y`, column `x` (0..8) sits at bits `[(9*y+x)*8 +: 8]` of `inWindow`, with offset dx = x−4, dy = y−4. Its weight is floor(floor(255·(16−idx)/16) / 2^floor((dx²+dy²)/8)), where idx is the R2 index.
- R4: `outProdSum` equals the exact sum over all 81 positions of pixel × weight, in 23 bits, with no overflow for any input.
- R5: `outWeightSum` equals the exact sum of all 81 weights, in 15 bits, with no overflow.
- R6: The center position always contributes weight 255, so every valid result has `outWeightSum` ≥ 255.
- R7: While `outValid` is low, `outProdSum` and `outWeightSum` keep the values of the last valid result.
- R8: During and right after reset, `outValid` is low and both totals are zero.
- R9: Windows with gaps or back-to-back arrive at the output in input order, each with its own totals, unaffected by the windows next to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | `inWindow` carries a window this cycle |
| inWindow | input | 648 | 81 packed 8-bit pixels, row-major, center at index 40 |
| outValid | output | 1 | Totals belong to a window accepted 8 edges earlier |
| outProdSum | output | 23 | Sum of pixel × weight over the window |
| outWeightSum | output | 15 | Sum of weights over the window |

## Verification
Two things can happen in the same cycle: a new window enters the element stage while the final tree level loads the result of an older window, or the output holds while windows are still in flight inside the tree. The bench provokes the first with a 256-window back-to-back sweep of the center value. It provokes the second with a gapped stream, where bubbles sit between live windows at every depth of the pipeline. Every output cycle is judged against totals that the bench recomputes from the weight formula. On each cycle it also checks that the result appears exactly 8 edges after its input and that the totals stay frozen on bubble cycles.

// File: rtl/bilat_pkg.sv
package bilat_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic peLoad;   // element stage captures a new window
    logic sumLoad;  // final tree level captures a new total
  } bilat_strobe_t;

  // Range-and-space weight, evaluated at elaboration only
  function automatic int gaussWeight(input int dx, input int dy, input int idx,
                                     input int depth, input int wMax);
    int rangePart;
    int spaceShift;
    rangePart  = (wMax * (depth - idx)) / depth;
    spaceShift = (dx * dx + dy * dy) / 8;
    return rangePart >> spaceShift;
  endfunction

endpackage

// File: rtl/bilat_pe.sv
module bilat_pe #(
  parameter int PIX_W  = 8,
  parameter int WT_W   = 8,
  parameter int ADDR_W = 4,
  parameter int DX     = 0,
  parameter int DY     = 0,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PROD_W = PIX_W + WT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [PIX_W-1:0]  pix,
  input  logic [PIX_W-1:0]  center,
  output logic [WT_W-1:0]   weight,
  output logic [PROD_W-1:0] product
);
  localparam int W_MAX = (1 << WT_W) - 1;

  logic [WT_W-1:0]  weightTbl [DEPTH];
  logic [PIX_W-1:0] absDiff;
  logic [ADDR_W-1:0] tblAddr;
  logic [WT_W-1:0]  weightNxt;

  generate
    for (genvar a = 0; a < DEPTH; a++) begin : g_tbl
      assign weightTbl[a] = WT_W'(bilat_pkg::gaussWeight(DX, DY, a, DEPTH, W_MAX));
    end
  endgenerate

  always_comb begin
    absDiff   = (pix >= center) ? (pix - center) : (center - pix);
    tblAddr   = absDiff[PIX_W-1 -: ADDR_W];
    weightNxt = weightTbl[tblAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weight  <= '0;
      product <= '0;
    end else if (load) begin
      weight  <= weightNxt;
      product <= PROD_W'(pix) * PROD_W'(weightNxt);
    end
  end
endmodule

// File: rtl/bilat_tree.sv
module bilat_tree #(
  parameter int N     = 81,
  parameter int IN_W  = 16,
  parameter int OUT_W = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lastLoad,
  input  logic [N*IN_W-1:0] leaves,
  output logic [OUT_W-1:0]  sum
);
  localparam int LEVELS = $clog2(N);
  localparam int LEAVES = 1 << LEVELS;

  logic [OUT_W-1:0] padded [LEAVES];

  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_pad
      if (i < N) begin : g_live
        assign padded[i] = OUT_W'(leaves[i*IN_W +: IN_W]);
      end else begin : g_zero
        assign padded[i] = '0;
      end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int CNT = LEAVES >> (l + 1);
      for (genvar j = 0; j < CNT; j++) begin : g_node
        logic [OUT_W-1:0] opA, opB, q;
        if (l == 0) begin : g_first
          assign opA = padded[2*j];
          assign opB = padded[2*j+1];
        end else begin : g_inner
          assign opA = g_lvl[l-1].g_node[2*j].q;
          assign opB = g_lvl[l-1].g_node[2*j+1].q;
        end
        if (l == LEVELS - 1) begin : g_root
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN)         q <= '0;
            else if (lastLoad) q <= opA + opB;
          end
        end else begin : g_mid
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) q <= '0;
            else       q <= opA + opB;
          end
        end
      end
    end
  endgenerate

  assign sum = g_lvl[LEVELS-1].g_node[0].q;
endmodule

// File: rtl/bilat_ctrl.sv
module bilat_ctrl #(
  parameter int LAT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output bilat_pkg::bilat_strobe_t strobes,
  output logic                    outValid
);
  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strobes.peLoad  = inValid;
    strobes.sumLoad = validPipe[LAT-2];
    outValid        = validPipe[LAT-1];
  end
endmodule

// File: rtl/bilat_datapath.sv
module bilat_datapath #(
  parameter int WIN    = 9,
  parameter int PIX_W  = 8,
  parameter int WT_W   = 8,
  parameter int ADDR_W = 4,
  localparam int N          = WIN * WIN,
  localparam int PROD_W     = PIX_W + WT_W,
  localparam int PSUM_W     = PROD_W + $clog2(N),
  localparam int WSUM_W     = WT_W + $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bilat_pkg::bilat_strobe_t strobes,
  input  logic [N*PIX_W-1:0]       window,
  output logic [PSUM_W-1:0]        prodSum,
  output logic [WSUM_W-1:0]        weightSum
);
  localparam int HALF   = WIN / 2;
  localparam int CENTER = HALF * WIN + HALF;

  logic [PIX_W-1:0]    centerPix;
  logic [N*WT_W-1:0]   weightVec;
  logic [N*PROD_W-1:0] prodVec;

  assign centerPix = window[CENTER*PIX_W +: PIX_W];

  generate
    for (genvar y = 0; y < WIN; y++) begin : g_row
      for (genvar x = 0; x < WIN; x++) begin : g_col
        localparam int IDX = y * WIN + x;
        bilat_pe #(
          .PIX_W (PIX_W),
          .WT_W  (WT_W),
          .ADDR_W(ADDR_W),
          .DX    (x - HALF),
          .DY    (y - HALF)
        ) i_pe (
          .clk    (clk),
          .rstN   (rstN),
          .load   (strobes.peLoad),
          .pix    (window[IDX*PIX_W +: PIX_W]),
          .center (centerPix),
          .weight (weightVec[IDX*WT_W +: WT_W]),
          .product(prodVec[IDX*PROD_W +: PROD_W])
        );
      end
    end
  endgenerate

  bilat_tree #(.N(N), .IN_W(PROD_W), .OUT_W(PSUM_W)) i_prodTree (
    .clk     (clk),
    .rstN    (rstN),
    .lastLoad(strobes.sumLoad),
    .leaves  (prodVec),
    .sum     (prodSum)
  );

  bilat_tree #(.N(N), .IN_W(WT_W), .OUT_W(WSUM_W)) i_weightTree (
    .clk     (clk),
    .rstN    (rstN),
    .lastLoad(strobes.sumLoad),
    .leaves  (weightVec),
    .sum     (weightSum)
  );
endmodule

// File: rtl/bilat_accum_top.sv
module bilat_accum_top #(
  parameter int WIN    = 9,
  parameter int PIX_W  = 8,
  parameter int WT_W   = 8,
  parameter int ADDR_W = 4,
  localparam int N      = WIN * WIN,
  localparam int PSUM_W = PIX_W + WT_W + $clog2(N),
  localparam int WSUM_W = WT_W + $clog2(N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [N*PIX_W-1:0] inWindow,
  output logic               outValid,
  output logic [PSUM_W-1:0]  outProdSum,
  output logic [WSUM_W-1:0]  outWeightSum
);
  localparam int LAT = 1 + $clog2(N);

  bilat_pkg::bilat_strobe_t strobes;

  bilat_ctrl #(.LAT(LAT)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  bilat_datapath #(
    .WIN(WIN), .PIX_W(PIX_W), .WT_W(WT_W), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .window   (inWindow),
    .prodSum  (outProdSum),
    .weightSum(outWeightSum)
  );
endmodule

// File: rtl/bilat_accum_checker.sv
module bilat_accum_checker #(
  parameter int WIN   = 9,
  parameter int PIX_W = 8,
  parameter int WT_W  = 8,
  localparam int N      = WIN * WIN,
  localparam int PSUM_W = PIX_W + WT_W + $clog2(N),
  localparam int WSUM_W = WT_W + $clog2(N),
  localparam int LAT    = 1 + $clog2(N)
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               outValid,
  input logic [PSUM_W-1:0]  outProdSum,
  input logic [WSUM_W-1:0]  outWeightSum
);
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int W_MAX   = (1 << WT_W) - 1;

  int sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceReset <= 0;
    else if (sinceReset < 1000) sinceReset <= sinceReset + 1;
  end

  // R1: output valid follows input valid by the pipeline depth
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= LAT) |-> (outValid == $past(inValid, LAT)));

  // R6: center weight keeps the weight total at or above its maximum
  p_center_weight_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outWeightSum >= WSUM_W'(W_MAX)));

  // R4: product total bounded by weight total times largest pixel
  p_prod_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outProdSum <= PSUM_W'(outWeightSum) * PSUM_W'(PIX_MAX)));

  // R7: totals frozen while no result is presented
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceReset >= 2) && !outValid) |-> ($stable(outProdSum) && $stable(outWeightSum)));

  // R8: reset clears the output side
  p_reset_r8: assert property (@(posedge clk)
    !rstN |=> (!outValid && outProdSum == '0 && outWeightSum == '0));
endmodule

bind bilat_accum_top bilat_accum_checker #(
  .WIN(WIN), .PIX_W(PIX_W), .WT_W(WT_W)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .outValid    (outValid),
  .outProdSum  (outProdSum),
  .outWeightSum(outWeightSum)
);

// File: tb/test_bilat_accum_top.sv
module test_bilat_accum_top;
  localparam int N = 81;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [N*8-1:0] inWindow = '0;
  logic          outValid;
  logic [22:0]   outProdSum;
  logic [14:0]   outWeightSum;

  bilat_accum_top i_bilat_accum_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWindow(inWindow),
    .outValid(outValid), .outProdSum(outProdSum), .outWeightSum(outWeightSum)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;
  int qP[$], qW[$], qC[$];
  int lastP = 0, lastW = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  // R3 weight formula with R2 indexing, computed from the requirements
  function automatic int refWeight(int pos, int p, int c);
    int dx, dy, d, idx;
    dx  = (pos % 9) - 4;
    dy  = (pos / 9) - 4;
    d   = (p > c) ? p - c : c - p;
    idx = d >> 4;
    return ((255 * (16 - idx)) / 16) >> ((dx * dx + dy * dy) / 8);
  endfunction

  task automatic observe();
    if (outValid) begin
      if (qP.size() == 0) begin
        check(0, "R9 unexpected result", 1, 0);
      end else begin
        int eP, eW, eC;
        eP = qP.pop_front(); eW = qW.pop_front(); eC = qC.pop_front();
        check(cyc == eC + 8, "R1 latency", cyc, eC + 8);
        check(int'(outProdSum) == eP, "R4 product sum", int'(outProdSum), eP);
        check(int'(outWeightSum) == eW, "R5 weight sum", int'(outWeightSum), eW);
        check(int'(outWeightSum) >= 255, "R6 weight floor", int'(outWeightSum), 255);
      end
      lastP = int'(outProdSum);
      lastW = int'(outWeightSum);
    end else begin
      check(int'(outProdSum) == lastP && int'(outWeightSum) == lastW,
            "R7 hold", int'(outProdSum), lastP);
      if (qC.size() > 0)
        check(cyc < qC[0] + 8, "R9 missing result", cyc, qC[0] + 8);
    end
  endtask

  // One cycle: judge outputs, then drive the next input
  task automatic step(input bit v, input logic [N*8-1:0] win);
    @(negedge clk);
    observe();
    inValid  = v;
    inWindow = win;
    if (v) begin
      int sp, sw, c;
      sp = 0; sw = 0;
      c  = int'(win[40*8 +: 8]);
      for (int i = 0; i < N; i++) begin
        int p, w;
        p = int'(win[i*8 +: 8]);
        w = refWeight(i, p, c);
        sp += p * w;
        sw += w;
      end
      qP.push_back(sp); qW.push_back(sw); qC.push_back(cyc);
    end
  endtask

  function automatic logic [N*8-1:0] flat(int base, int ctr, int mode);
    logic [N*8-1:0] w;
    for (int i = 0; i < N; i++) begin
      int v;
      case (mode)
        0: v = base;
        1: v = (i == 40) ? ctr : base;
        default: v = (i * 37 + ctr * 11 + base) & 255;
      endcase
      w[i*8 +: 8] = 8'(v);
    end
    return w;
  endfunction

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 valid in reset", int'(outValid), 0);
    check(outProdSum == '0 && outWeightSum == '0, "R8 sums in reset", int'(outWeightSum), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outWeightSum == '0, "R8 after reset", int'(outValid), 0);

    // Flat windows: pure spatial weights (R3), extreme differences (R2)
    step(1, flat(100, 0, 0));
    step(1, flat(255, 0, 1));
    step(1, flat(0, 255, 1));
    step(1, flat(0, 0, 0));
    step(1, flat(255, 255, 0));
    step(1, flat(15, 0, 1));   // difference 15 stays in index 0
    step(1, flat(16, 0, 1));   // difference 16 moves to index 1
    for (int k = 0; k < 12; k++) step(0, '0);

    // Back-to-back sweep of center value: load and accept in the same cycle (R9)
    for (int c = 0; c < 256; c++) step(1, flat(c, c, 2));
    for (int k = 0; k < 12; k++) step(0, '0);

    // Gapped stream: bubbles at every pipeline depth (R7, R9)
    for (int c = 0; c < 64; c++) begin
      step(1, flat(c * 3, 255 - c, 2));
      for (int g = 0; g < (c % 4); g++) step(0, flat(c, 7, 2));
    end
    for (int k = 0; k < 12; k++) step(0, '0);

    check(qP.size() == 0, "R9 drained", qP.size(), 0);
    finishRun();
  end
endmodule